// File: doc/BRIEF.md
# ACPI Fixed-Function Power-Management Registers

This block holds the fixed-function power-management registers that an operating system reaches over a byte-addressed I/O bus. It has an event status register and an event enable register, a control register that carries the interrupt-enable flag and the sleep request, a one-byte general-purpose-event status/enable pair, a write-only command port that turns interrupt delivery on or off, and a one-byte reset control register. A transfer names its start address and its size in bytes. Each register accepts only its own access size.

Two kinds of event come in on the event side: a power-button pulse and per-bit general-purpose-event raise requests. From these the block keeps a level-sensitive SCI output. SCI is high while any interrupt-capable event is both pending and enabled. Two writes turn into one-cycle pulses. A sleep request with sleep type 5 pulses `poweroff_pulse`, and a reset-control write with its go bit set pulses `reset_pulse`. Timers, interrupt routing and the actual power sequencing live outside the block.

Top module: `acpi_pm_regs`

## Requirements
- R1: A write to the event status register (16-bit, default offset 0x00) clears the bits at positions 15, 10, 9, 8 and 4 wherever the data has a 1. Every other status bit keeps its value.
- R2: A write to the event enable register (16-bit, default offset 0x02) stores only bits 10, 8 and 5. Every other enable bit reads as 0.
- R3: `sci` is high in the cycle after a state change exactly when (status & enable & 0x0721) is nonzero or (gpe status & gpe enable) is nonzero. It does not change in a cycle with no transfer and no event.
- R4: The event status, event enable and control registers accept only size 2. The gpe status, gpe enable, command and reset registers accept only size 1. Any other size returns `bus_err`=1 and `bus_rdata`=0, and changes no state.
- R5: A write to the control register (16-bit, default offset 0x04) keeps bit 0 (interrupt enable) and stores bits 15, 14, 13, 1 and 0 as 0. All other bits, including sleep type in bits 12:10, take the data.
- R6: A control write whose data has bit 13 set and bits 12:10 equal to 5 makes `poweroff_pulse` high for exactly the one cycle after the write. No other transfer raises it.
- R7: A `pwrbtn_evt` cycle sets status bit 8. If a clearing write lands in the same cycle, the event wins.
- R8: Only gpe bit GPE_VALID_IDX (default 0) exists. A raise sets it. A status write (default offset 0x08) clears it where the data is 1. An enable write (default offset 0x09) stores the data masked to that bit. All other gpe bits read 0.
- R9: Writing SMI_ON (default 0xA0) to the command port (default offset 0x0A) sets control bit 0. Writing SMI_OFF (default 0xA1) clears it. Any other code changes nothing. A read of the port returns 0x00FF.
- R10: The reset register (default offset 0x0F) reads back the last byte written. A write with bit 2 set makes `reset_pulse` high for exactly the one cycle after the write, whatever bit 1 holds.
- R11: A transfer to an unmapped address reads 0xFFFF with no error and a write there changes nothing.
- R12: Every cycle with `bus_valid` high is answered by `bus_ready` high in the next cycle and only then. `bus_err` is high only together with `bus_ready`.
- R13: After reset every register reads 0 and `sci`, `poweroff_pulse` and `reset_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Transfer request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Start byte address |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 16 | Write data |
| bus_ready | output | 1 | Response strobe, one cycle after the request |
| bus_err | output | 1 | Size rejected |
| bus_rdata | output | 16 | Read data, valid with bus_ready |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| gpe_raise | input | GPE_W | General-purpose-event raise requests |
| sci | output | 1 | Level interrupt request |
| poweroff_pulse | output | 1 | Soft power-off request |
| reset_pulse | output | 1 | System reset request |

## Verification
A wrong status, enable or gpe bit shows up in two places one cycle after the write or event that caused it: on the read-back of that register, and on `sci`. So each sweep reads the register and samples `sci` at the same response edge. A control bit stored with the wrong mask shows on the next read of the control register, and a wrongly kept interrupt-enable bit shows once the command port has been swept through all 256 codes. A sleep-type or reset decode fault shows as a pulse that is missing, or present, in the single cycle after the write. It is caught there, because the pulse never comes back later.

// File: rtl/acpi_pm_pkg.sv
`timescale 1ns/1ps
package acpi_pm_pkg;
   localparam int REG_W = 16;

   // event status bits that software may clear (write one to clear)
   localparam logic [REG_W-1:0] STS_CLR_MASK = 16'h8710;
   // event enable bits that are stored
   localparam logic [REG_W-1:0] EN_KEEP_MASK = 16'h0520;
   // event bits able to raise the interrupt
   localparam logic [REG_W-1:0] SCI_SRC_MASK = 16'h0721;
   // control bits always stored as zero (sleep enable plus reserved)
   localparam logic [REG_W-1:0] CTL_ZERO_MASK = 16'hE003;

   localparam int PWRBTN_BIT  = 8;
   localparam int SCI_EN_BIT  = 0;
   localparam int SLP_EN_BIT  = 13;
   localparam int SLP_TYP_LO  = 10;
   localparam int SLP_TYP_HI  = 12;
   localparam logic [2:0] SLP_TYP_OFF = 3'd5;
   localparam int RST_GO_BIT  = 2;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_STS, SEL_EN, SEL_CTL, SEL_GSTS, SEL_GEN, SEL_CMD, SEL_RST
   } reg_sel_e;
endpackage

// File: rtl/acpi_pm_decode.sv
`timescale 1ns/1ps
module acpi_pm_decode
   import acpi_pm_pkg::*;
#(
   parameter int unsigned          ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]    STS_OFS  = 'h00,
   parameter logic [ADDR_W-1:0]    EN_OFS   = 'h02,
   parameter logic [ADDR_W-1:0]    CTL_OFS  = 'h04,
   parameter logic [ADDR_W-1:0]    GSTS_OFS = 'h08,
   parameter logic [ADDR_W-1:0]    GEN_OFS  = 'h09,
   parameter logic [ADDR_W-1:0]    CMD_OFS  = 'h0A,
   parameter logic [ADDR_W-1:0]    RST_OFS  = 'h0F
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   output reg_sel_e          sel,
   output logic              size_ok
);
   always_comb begin
      sel = SEL_NONE;
      if (addr == STS_OFS)  sel = SEL_STS;
      if (addr == EN_OFS)   sel = SEL_EN;
      if (addr == CTL_OFS)  sel = SEL_CTL;
      if (addr == GSTS_OFS) sel = SEL_GSTS;
      if (addr == GEN_OFS)  sel = SEL_GEN;
      if (addr == CMD_OFS)  sel = SEL_CMD;
      if (addr == RST_OFS)  sel = SEL_RST;
   end

   always_comb begin
      unique case (sel)
         SEL_STS, SEL_EN, SEL_CTL: size_ok = (size == 3'd2);
         SEL_NONE:                 size_ok = 1'b1;
         default:                  size_ok = (size == 3'd1);
      endcase
   end
endmodule

// File: rtl/acpi_pm_evt.sv
`timescale 1ns/1ps
module acpi_pm_evt
   import acpi_pm_pkg::*;
#(
   parameter int unsigned GPE_W         = 8,
   parameter int unsigned GPE_VALID_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sts,
   input  logic             wr_en,
   input  logic             wr_gsts,
   input  logic             wr_gen,
   input  logic [REG_W-1:0] wdata,
   input  logic             pwrbtn_evt,
   input  logic [GPE_W-1:0] gpe_raise,
   output logic [REG_W-1:0] sts_q,
   output logic [REG_W-1:0] en_q,
   output logic [GPE_W-1:0] gsts_q,
   output logic [GPE_W-1:0] gen_q,
   output logic             sci
);
   logic [GPE_W-1:0] gpe_valid;
   for (genvar i = 0; i < GPE_W; i++) begin : g_valid
      assign gpe_valid[i] = (i == GPE_VALID_IDX);
   end

   logic [REG_W-1:0] sts_d;
   logic [GPE_W-1:0] gsts_d;

   always_comb begin
      sts_d = sts_q;
      if (wr_sts) sts_d = sts_d & ~(wdata & STS_CLR_MASK);
      if (pwrbtn_evt) sts_d[PWRBTN_BIT] = 1'b1;
   end

   always_comb begin
      gsts_d = gsts_q;
      if (wr_gsts) gsts_d = gsts_d & ~(wdata[GPE_W-1:0] & gpe_valid);
      gsts_d = gsts_d | (gpe_raise & gpe_valid);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q  <= '0;
         en_q   <= '0;
         gsts_q <= '0;
         gen_q  <= '0;
      end else begin
         sts_q  <= sts_d;
         gsts_q <= gsts_d;
         if (wr_en)  en_q  <= wdata & EN_KEEP_MASK;
         if (wr_gen) gen_q <= wdata[GPE_W-1:0] & gpe_valid;
      end
   end

   assign sci = (|(sts_q & en_q & SCI_SRC_MASK)) | (|(gsts_q & gen_q));
endmodule

// File: rtl/acpi_pm_ctl.sv
`timescale 1ns/1ps
module acpi_pm_ctl
   import acpi_pm_pkg::*;
#(
   parameter logic [7:0] SMI_ON  = 8'hA0,
   parameter logic [7:0] SMI_OFF = 8'hA1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctl,
   input  logic             wr_cmd,
   input  logic             wr_rst,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] ctl_q,
   output logic [7:0]       rst_q,
   output logic             poweroff_pulse,
   output logic             reset_pulse
);
   logic sleep_off_req;
   assign sleep_off_req = wdata[SLP_EN_BIT] &&
                          (wdata[SLP_TYP_HI:SLP_TYP_LO] == SLP_TYP_OFF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q          <= '0;
         rst_q          <= '0;
         poweroff_pulse <= 1'b0;
         reset_pulse    <= 1'b0;
      end else begin
         if (wr_ctl) begin
            ctl_q <= (wdata & ~CTL_ZERO_MASK) |
                     (ctl_q & (REG_W'(1) << SCI_EN_BIT));
         end else if (wr_cmd) begin
            if (wdata[7:0] == SMI_ON)       ctl_q[SCI_EN_BIT] <= 1'b1;
            else if (wdata[7:0] == SMI_OFF) ctl_q[SCI_EN_BIT] <= 1'b0;
         end
         if (wr_rst) rst_q <= wdata[7:0];
         poweroff_pulse <= wr_ctl && sleep_off_req;
         reset_pulse    <= wr_rst && wdata[RST_GO_BIT];
      end
   end
endmodule

// File: rtl/acpi_pm_regs.sv
`timescale 1ns/1ps
module acpi_pm_regs
   import acpi_pm_pkg::*;
#(
   parameter int unsigned          ADDR_W        = 8,
   parameter int unsigned          GPE_W         = 8,
   parameter int unsigned          GPE_VALID_IDX = 0,
   parameter logic [7:0]           SMI_ON        = 8'hA0,
   parameter logic [7:0]           SMI_OFF       = 8'hA1,
   parameter logic [ADDR_W-1:0]    STS_OFS       = 'h00,
   parameter logic [ADDR_W-1:0]    EN_OFS        = 'h02,
   parameter logic [ADDR_W-1:0]    CTL_OFS       = 'h04,
   parameter logic [ADDR_W-1:0]    GSTS_OFS      = 'h08,
   parameter logic [ADDR_W-1:0]    GEN_OFS       = 'h09,
   parameter logic [ADDR_W-1:0]    CMD_OFS       = 'h0A,
   parameter logic [ADDR_W-1:0]    RST_OFS       = 'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [2:0]        bus_size,
   input  logic [15:0]       bus_wdata,
   output logic              bus_ready,
   output logic              bus_err,
   output logic [15:0]       bus_rdata,
   input  logic              pwrbtn_evt,
   input  logic [GPE_W-1:0]  gpe_raise,
   output logic              sci,
   output logic              poweroff_pulse,
   output logic              reset_pulse
);
   localparam int N_OFS = 7;
   localparam logic [ADDR_W-1:0] OFS_LIST [N_OFS] =
      '{STS_OFS, EN_OFS, CTL_OFS, GSTS_OFS, GEN_OFS, CMD_OFS, RST_OFS};

   // elaboration-time parameter checks
   for (genvar i = 0; i < N_OFS; i++) begin : g_ofs_i
      for (genvar j = i + 1; j < N_OFS; j++) begin : g_ofs_j
         if (OFS_LIST[i] == OFS_LIST[j]) begin : g_clash
            $error("acpi_pm_regs: register offsets collide");
         end
      end
   end
   if (GPE_W < 1 || GPE_W > 8) begin : g_bad_gpe_w
      $error("acpi_pm_regs: GPE_W must be 1..8");
   end
   if (GPE_VALID_IDX >= GPE_W) begin : g_bad_gpe_idx
      $error("acpi_pm_regs: GPE_VALID_IDX out of range");
   end
   if (SMI_ON == SMI_OFF) begin : g_bad_smi
      $error("acpi_pm_regs: command codes must differ");
   end

   reg_sel_e sel;
   logic     size_ok;

   acpi_pm_decode #(
      .ADDR_W(ADDR_W), .STS_OFS(STS_OFS), .EN_OFS(EN_OFS), .CTL_OFS(CTL_OFS),
      .GSTS_OFS(GSTS_OFS), .GEN_OFS(GEN_OFS), .CMD_OFS(CMD_OFS), .RST_OFS(RST_OFS)
   ) u_decode (
      .addr(bus_addr), .size(bus_size), .sel(sel), .size_ok(size_ok)
   );

   logic wr_ok;
   assign wr_ok = bus_valid && bus_write && size_ok;

   logic [REG_W-1:0] sts_q, en_q, ctl_q;
   logic [GPE_W-1:0] gsts_q, gen_q;
   logic [7:0]       rst_q;

   acpi_pm_evt #(.GPE_W(GPE_W), .GPE_VALID_IDX(GPE_VALID_IDX)) u_evt (
      .clk(clk), .rst_n(rst_n),
      .wr_sts(wr_ok && sel == SEL_STS), .wr_en(wr_ok && sel == SEL_EN),
      .wr_gsts(wr_ok && sel == SEL_GSTS), .wr_gen(wr_ok && sel == SEL_GEN),
      .wdata(bus_wdata), .pwrbtn_evt(pwrbtn_evt), .gpe_raise(gpe_raise),
      .sts_q(sts_q), .en_q(en_q), .gsts_q(gsts_q), .gen_q(gen_q), .sci(sci)
   );

   acpi_pm_ctl #(.SMI_ON(SMI_ON), .SMI_OFF(SMI_OFF)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .wr_ctl(wr_ok && sel == SEL_CTL), .wr_cmd(wr_ok && sel == SEL_CMD),
      .wr_rst(wr_ok && sel == SEL_RST), .wdata(bus_wdata),
      .ctl_q(ctl_q), .rst_q(rst_q),
      .poweroff_pulse(poweroff_pulse), .reset_pulse(reset_pulse)
   );

   logic [15:0] rd_mux;
   always_comb begin
      unique case (sel)
         SEL_STS:  rd_mux = sts_q;
         SEL_EN:   rd_mux = en_q;
         SEL_CTL:  rd_mux = ctl_q;
         SEL_GSTS: rd_mux = 16'(gsts_q);
         SEL_GEN:  rd_mux = 16'(gen_q);
         SEL_CMD:  rd_mux = 16'h00FF;
         SEL_RST:  rd_mux = 16'(rst_q);
         default:  rd_mux = 16'hFFFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_ready <= 1'b0;
         bus_err   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ready <= bus_valid;
         bus_err   <= bus_valid && !size_ok;
         bus_rdata <= (bus_valid && !bus_write && size_ok) ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/acpi_pm_regs_chk.sv
`timescale 1ns/1ps
module acpi_pm_regs_chk #(
   parameter int unsigned       ADDR_W  = 8,
   parameter int unsigned       GPE_W   = 8,
   parameter logic [ADDR_W-1:0] CTL_OFS = 'h04,
   parameter logic [ADDR_W-1:0] RST_OFS = 'h0F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [2:0]        bus_size,
   input logic [15:0]       bus_wdata,
   input logic              bus_ready,
   input logic              bus_err,
   input logic [15:0]       bus_rdata,
   input logic              pwrbtn_evt,
   input logic [GPE_W-1:0]  gpe_raise,
   input logic              sci,
   input logic              poweroff_pulse,
   input logic              reset_pulse
);
   // R12
   ready_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> bus_ready);
   // R12
   no_spurious_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !bus_ready);
   // R12
   err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> bus_ready);
   // R6
   poweroff_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poweroff_pulse |=> !poweroff_pulse);
   // R6
   poweroff_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poweroff_pulse |-> $past(bus_valid && bus_write && bus_addr == CTL_OFS &&
                               bus_size == 3'd2 && bus_wdata[13] &&
                               bus_wdata[12:10] == 3'd5));
   // R10
   reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_pulse |=> !reset_pulse);
   // R10
   reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_pulse |-> $past(bus_valid && bus_write && bus_addr == RST_OFS &&
                            bus_size == 3'd1 && bus_wdata[2]));
   // R3
   sci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_valid && !pwrbtn_evt && gpe_raise == '0) |=> $stable(sci));
endmodule

bind acpi_pm_regs acpi_pm_regs_chk #(
   .ADDR_W(ADDR_W), .GPE_W(GPE_W), .CTL_OFS(CTL_OFS), .RST_OFS(RST_OFS)
) u_chk (.*);

// File: tb/acpi_pm_regs_tb.sv
`timescale 1ns/1ps
module acpi_pm_regs_tb;
   localparam logic [7:0] A_STS = 8'h00, A_EN = 8'h02, A_CTL = 8'h04,
                          A_GSTS = 8'h08, A_GEN = 8'h09, A_CMD = 8'h0A,
                          A_RST = 8'h0F, A_HOLE = 8'h40;
   localparam logic [7:0] C_ON = 8'hA0, C_OFF = 8'hA1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [2:0] bus_size = '0;
   logic [15:0] bus_wdata = '0;
   logic bus_ready, bus_err, sci, poweroff_pulse, reset_pulse;
   logic [15:0] bus_rdata;
   logic pwrbtn_evt = 1'b0;
   logic [7:0] gpe_raise = '0;

   acpi_pm_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata),
      .pwrbtn_evt(pwrbtn_evt), .gpe_raise(gpe_raise), .sci(sci),
      .poweroff_pulse(poweroff_pulse), .reset_pulse(reset_pulse)
   );

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;
   logic [15:0] r_rd;
   logic r_rdy, r_err, r_po, r_rs;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic w, input logic [7:0] a, input logic [2:0] s,
                       input logic [15:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_size = s; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0;
      r_rd = bus_rdata; r_rdy = bus_ready; r_err = bus_err;
      r_po = poweroff_pulse; r_rs = reset_pulse;
      check("R12 ready", {31'd0, r_rdy}, 1);
   endtask

   task automatic wr(input logic [7:0] a, input logic [2:0] s, input logic [15:0] d);
      xfer(1'b1, a, s, d);
   endtask

   task automatic rd(input logic [7:0] a, input logic [2:0] s);
      xfer(1'b0, a, s, 16'h0);
   endtask

   task automatic press;
      @(negedge clk); pwrbtn_evt = 1'b1;
      @(negedge clk); pwrbtn_evt = 1'b0;
   endtask

   task automatic raise(input logic [7:0] m);
      @(negedge clk); gpe_raise = m;
      @(negedge clk); gpe_raise = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL R12 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] exp_ctl;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R13 reset state
      check("R13 sci", {31'd0, sci}, 0);
      check("R13 poweroff", {31'd0, poweroff_pulse}, 0);
      check("R13 reset pulse", {31'd0, reset_pulse}, 0);
      rd(A_STS, 2);  check("R13 status", r_rd, 0);
      rd(A_EN, 2);   check("R13 enable", r_rd, 0);
      rd(A_CTL, 2);  check("R13 control", r_rd, 0);
      rd(A_GSTS, 1); check("R13 gpe status", r_rd, 0);
      rd(A_GEN, 1);  check("R13 gpe enable", r_rd, 0);
      rd(A_RST, 1);  check("R13 reset reg", r_rd, 0);
      rd(A_CMD, 1);  check("R9 command read", r_rd, 16'h00FF);

      // R2 enable mask sweep
      for (int b = 0; b < 16; b++) begin
         wr(A_EN, 2, 16'(1) << b);
         rd(A_EN, 2);
         check("R2 enable bit", r_rd, (16'(1) << b) & 16'h0520);
         check("R12 no err", {31'd0, r_err}, 0);
      end
      wr(A_EN, 2, 16'hFFFF); rd(A_EN, 2); check("R2 enable all", r_rd, 16'h0520);

      // R7 / R3 / R1 power button path
      wr(A_EN, 2, 16'h0020);
      press;
      check("R3 masked by enable", {31'd0, sci}, 0);
      rd(A_STS, 2); check("R7 pwrbtn status", r_rd, 16'h0100);
      wr(A_EN, 2, 16'h0100);
      check("R3 sci on", {31'd0, sci}, 1);
      wr(A_STS, 2, 16'hFEFF);
      rd(A_STS, 2); check("R1 other bits no clear", r_rd, 16'h0100);
      check("R3 sci held", {31'd0, sci}, 1);
      wr(A_STS, 2, 16'h0100);
      check("R3 sci off", {31'd0, sci}, 0);
      rd(A_STS, 2); check("R1 clear pwrbtn", r_rd, 0);
      // R7 event beats same-cycle clear
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_STS; bus_size = 3'd2;
      bus_wdata = 16'hFFFF; pwrbtn_evt = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0; pwrbtn_evt = 1'b0;
      rd(A_STS, 2); check("R7 event wins", r_rd, 16'h0100);
      wr(A_STS, 2, 16'h0100);

      // R4 size rejection
      for (int s = 0; s < 8; s++) begin
         if (s != 2) begin
            wr(A_EN, 3'(s), 16'h0000);
            check("R4 err enable", {31'd0, r_err}, 1);
            rd(A_EN, 2); check("R4 enable kept", r_rd, 16'h0100);
            wr(A_CTL, 3'(s), 16'h3400);
            check("R4 no poweroff", {31'd0, r_po}, 0);
            rd(A_STS, 3'(s));
            check("R4 err read", {31'd0, r_err}, 1);
            check("R4 read data zero", r_rd, 0);
         end
         if (s != 1) begin
            wr(A_RST, 3'(s), 16'h0006);
            check("R4 err reset", {31'd0, r_err}, 1);
            check("R4 no reset pulse", {31'd0, r_rs}, 0);
            wr(A_GEN, 3'(s), 16'h00FF);
            check("R4 err gpe", {31'd0, r_err}, 1);
         end
      end
      rd(A_RST, 1); check("R4 reset reg kept", r_rd, 0);
      rd(A_GEN, 1); check("R4 gpe enable kept", r_rd, 0);
      rd(A_CTL, 2); check("R4 control kept", r_rd, 0);

      // R5 / R6 control sweep with interrupt enable set
      wr(A_CMD, 1, {8'h0, C_ON});
      for (int t = 0; t < 8; t++) begin
         for (int e = 0; e < 2; e++) begin
            logic [15:0] d;
            d = 16'hC3FF | (16'(t) << 10) | (16'(e) << 13);
            wr(A_CTL, 2, d);
            check("R6 poweroff pulse", {31'd0, r_po}, (e == 1 && t == 5) ? 1 : 0);
            exp_ctl = 16'h0001 | (d & ~16'hE003);
            rd(A_CTL, 2); check("R5 control", r_rd, exp_ctl);
            check("R6 pulse gone", {31'd0, r_po}, 0);
         end
      end
      wr(A_CMD, 1, {8'h0, C_OFF});
      wr(A_CTL, 2, 16'h0001);
      rd(A_CTL, 2); check("R5 interrupt enable not writable", r_rd, 0);

      // R9 command code sweep
      for (int c = 0; c < 256; c++) begin
         wr(A_CMD, 1, {8'h0, C_OFF});
         wr(A_CMD, 1, 16'(c));
         rd(A_CTL, 2);
         check("R9 code from off", {31'd0, r_rd[0]}, (c == C_ON) ? 1 : 0);
         wr(A_CMD, 1, {8'h0, C_ON});
         wr(A_CMD, 1, 16'(c));
         rd(A_CTL, 2);
         check("R9 code from on", {31'd0, r_rd[0]}, (c == C_OFF) ? 0 : 1);
      end

      // R8 gpe
      for (int i = 0; i < 8; i++) begin
         raise(8'(1) << i);
         rd(A_GSTS, 1); check("R8 raise", r_rd, (i == 0) ? 1 : 0);
         wr(A_GSTS, 1, 16'h00FF);
      end
      wr(A_GEN, 1, 16'h00FF); rd(A_GEN, 1); check("R8 enable mask", r_rd, 16'h0001);
      raise(8'hFF);
      check("R3 gpe sci on", {31'd0, sci}, 1);
      wr(A_GSTS, 1, 16'h00FE);
      rd(A_GSTS, 1); check("R8 w1c masked", r_rd, 16'h0001);
      wr(A_GSTS, 1, 16'h0001);
      check("R3 gpe sci off", {31'd0, sci}, 0);
      rd(A_GSTS, 1); check("R8 cleared", r_rd, 0);

      // R10 reset register sweep
      for (int v = 0; v < 256; v++) begin
         wr(A_RST, 1, 16'(v));
         check("R10 reset pulse", {31'd0, r_rs}, ((v >> 2) & 1) ? 1 : 0);
         rd(A_RST, 1);
         check("R10 readback", r_rd, 16'(v));
         check("R10 pulse gone", {31'd0, r_rs}, 0);
      end

      // R11 unmapped
      rd(A_HOLE, 2); check("R11 hole read", r_rd, 16'hFFFF);
      check("R11 no err", {31'd0, r_err}, 0);
      wr(A_HOLE, 1, 16'hFFFF);
      rd(A_EN, 2); check("R11 enable untouched", r_rd, 16'h0100);
      rd(A_RST, 1); check("R11 reset reg untouched", r_rd, 16'h00FF);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule